// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads the leading bytes of a device configuration image, one byte per handshake. It finds where the raw configuration payload starts and how many payload bytes follow. A pulse on `start_i` begins a new image at offset 0. The parser then pulls bytes through a valid/ready handshake into a local buffer. It takes only as many bytes as the header walk needs. When the walk ends, it reports the payload offset and the payload byte count together with a one-cycle completion pulse and an error flag. Payload bytes are left for downstream logic, and the block never touches them.

The walk has three steps. First, the base header length and the record count are read. Next, a table of fixed-size records is scanned for two tags: one gives the payload offset and the other gives the location of a table of packed segment lengths. Finally, the segment lengths are summed and scaled to bytes. Every position the walk needs is checked against the buffer depth. A position that does not fit ends the walk with an error rather than an out-of-range read.

Top module: `hdr_image_parser`

## Requirements
- R1: After reset, `byte_ready_o`, `done_o` and `err_o` are 0, and both result outputs are 0.
- R2: A byte is taken only in a cycle where `byte_valid_i` and `byte_ready_o` are both 1. After a start, the number of bytes taken before `done_o` equals the largest position the walk has needed so far. That position is never below 71. It includes the base header length, the end of the record table, the payload offset, and for each length field i the table offset + floor(22·i/8) + 4. `byte_ready_o` is 0 once the walk has ended.
- R3: The byte at position 24 is the base header length L. The byte at position L−1 is the record count N. N records of 9 bytes each follow from position L. In each record, byte 0 is a tag and bytes 1..4 are a 32-bit little-endian offset.
- R4: Tag value 8 gives the payload offset, which appears on `data_start_o`. Tag value 5 gives the length-table offset. All other tag values change nothing.
- R5: The scan stops at the first record after which both offsets are non-zero. Records after that point are not examined.
- R6: If the records run out while either offset is still zero, `err_o` is 1 with `done_o`, and both result outputs stay 0.
- R7: The segment count is a 16-bit little-endian value at positions 55..56. Segment i is a 22-bit field that starts at bit 22·i of the length table, counted LSB first within each byte. `data_size_o` is 16 times the sum of all segments, modulo 2^32.
- R8: A base header length of 0, or any needed position beyond `BUF_DEPTH`, ends the walk with `err_o` set. No byte is taken past the last position that fits.
- R9: `done_o` is high for exactly one cycle per walk. The results and `err_o` hold until the next start, and a start clears them to 0 one cycle later.
- R10: A segment count of 0 gives `data_size_o` = 0 with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new image at offset 0 |
| byte_valid_i | input | 1 | Incoming byte present |
| byte_i | input | 8 | Incoming image byte |
| byte_ready_o | output | 1 | Parser accepts a byte this cycle |
| data_start_o | output | 32 | Payload offset within the image |
| data_size_o | output | 32 | Payload length in bytes |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Walk ended in error |

## Verification
One image puts an ignored tag ahead of both wanted tags and uses packed lengths that include an all-ones field. This shows whether the 22-bit fields are aligned correctly across byte boundaries. A second image has the payload tag first, a decoy duplicate after both tags are found, a length table that reaches past the payload offset, and a stalled input. Together these separate early scan termination from last-match behaviour, and a demand-driven fill from a fixed-length one. Further images have a missing or zero tag offset, a payload offset beyond the buffer, a zero base length and an empty length table. Each of these must finish with a known error state after a known number of bytes have been taken.

// File: rtl/hdr_parse_pkg.sv
package hdr_parse_pkg;

    // fixed positions and sizes of the image header layout
    localparam int unsigned BASE_POS    = 24;
    localparam int unsigned COUNT_POS   = 55;
    localparam int unsigned MIN_FILL    = 71;
    localparam int unsigned REC_LEN     = 9;
    localparam int unsigned FIELD_W     = 22;
    localparam int unsigned FRAME_SHIFT = 4;
    localparam int unsigned WIN_BYTES   = 5;

    localparam logic [7:0] TAG_PAYLOAD = 8'd8;
    localparam logic [7:0] TAG_LENGTHS = 8'd5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL,
        S_BASE,
        S_NREC,
        S_TABLE,
        S_REC,
        S_CHECK,
        S_REACH,
        S_COUNT,
        S_FIELD
    } phase_t;

    typedef struct packed {
        logic [31:0] data_at;
        logic [31:0] sizes_at;
    } locs_t;

    typedef struct packed {
        logic [31:0] start;
        logic [31:0] size;
    } result_t;

    // end (exclusive) of the record table
    function automatic logic [33:0] table_limit(input logic [7:0] base,
                                                input logic [7:0] nrec);
        return 34'(base) + 34'(nrec) * 34'(REC_LEN);
    endfunction

    // end (exclusive) of the 4-byte window holding one length field
    function automatic logic [33:0] field_limit(input logic [31:0] table_at,
                                                input logic [31:0] bit_pos);
        return {2'b00, table_at} + {5'b0, bit_pos[31:3]} + 34'd4;
    endfunction

endpackage

// File: rtl/hdr_byte_buf.sv
module hdr_byte_buf
    import hdr_parse_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned CW    = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   fill_en,
    input  logic [CW-1:0]          fill_need,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_in,
    output logic                   byte_ready,
    output logic [CW-1:0]          count,
    input  logic [31:0]            rd_addr,
    output logic [8*WIN_BYTES-1:0] window
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem [DEPTH];
    logic       take;

    assign byte_ready = fill_en && (count < fill_need);
    assign take       = byte_valid && byte_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (take) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take && !clear) begin
            mem[count[AW-1:0]] <= byte_in;
        end
    end

    // little-endian read window, zero outside the buffer
    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_win
        logic [32:0] pos;
        assign pos = {1'b0, rd_addr} + 33'(k);
        assign window[8*k +: 8] = (pos < 33'(DEPTH)) ? mem[pos[AW-1:0]] : 8'h00;
    end

    // R8
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> $stable(count));

endmodule

// File: rtl/hdr_field_acc.sv
module hdr_field_acc
    import hdr_parse_pkg::*;
(
    input  logic [31:0] window,
    input  logic [2:0]  shift,
    input  logic [31:0] sum_in,
    output logic [31:0] sum_out
);

    logic [31:0]        shifted;
    logic [FIELD_W-1:0] field;

    always_comb begin
        shifted = window >> shift;
        field   = shifted[FIELD_W-1:0];
        sum_out = sum_in + 32'(field);
    end

endmodule

// File: rtl/hdr_parse_ctrl.sv
module hdr_parse_ctrl
    import hdr_parse_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned CW    = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CW-1:0]          count,
    output logic                   fill_en,
    output logic [CW-1:0]          fill_need,
    output logic [31:0]            rd_addr,
    input  logic [8*WIN_BYTES-1:0] window,
    output logic [2:0]             field_shift,
    output logic [31:0]            acc_sum,
    input  logic [31:0]            acc_next,
    output logic [31:0]            data_start,
    output logic [31:0]            data_size,
    output logic                   done,
    output logic                   err
);

    phase_t      state, resume;
    logic [CW-1:0] need_q;
    logic [7:0]  base_q, recs_q;
    logic [31:0] rec_at;
    locs_t       loc_q, loc_nx;
    logic [15:0] comps_q;
    logic [31:0] bitpos_q, sum_q;
    result_t     res_q;
    logic        done_q, err_q;

    logic [33:0] need;
    logic        need_on, over, short;
    logic [7:0]  win_tag;
    logic [31:0] win_off;
    logic        both_found;

    assign win_tag = window[7:0];
    assign win_off = window[39:8];

    // position needed by the current phase and read address
    always_comb begin
        need    = '0;
        need_on = 1'b0;
        rd_addr = '0;
        case (state)
            S_BASE: begin
                need_on = 1'b1;
                need    = 34'(MIN_FILL);
                rd_addr = 32'(BASE_POS);
            end
            S_NREC: begin
                need_on = 1'b1;
                need    = 34'(base_q);
                rd_addr = 32'(base_q) - 32'd1;
            end
            S_TABLE: begin
                need_on = 1'b1;
                need    = table_limit(base_q, recs_q);
            end
            S_REC: begin
                rd_addr = rec_at;
            end
            S_REACH: begin
                need_on = 1'b1;
                need    = {2'b00, loc_q.data_at};
            end
            S_COUNT: begin
                rd_addr = 32'(COUNT_POS);
            end
            S_FIELD: begin
                need_on = (comps_q != 16'd0);
                need    = field_limit(loc_q.sizes_at, bitpos_q);
                rd_addr = loc_q.sizes_at + {3'b000, bitpos_q[31:3]};
            end
            default: ;
        endcase
    end

    assign over  = need > 34'(DEPTH);
    assign short = need > 34'(count);

    // record decode
    always_comb begin
        loc_nx = loc_q;
        if (win_tag == TAG_PAYLOAD) loc_nx.data_at  = win_off;
        if (win_tag == TAG_LENGTHS) loc_nx.sizes_at = win_off;
        both_found = (loc_nx.data_at != 32'd0) && (loc_nx.sizes_at != 32'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            resume   <= S_IDLE;
            need_q   <= '0;
            base_q   <= '0;
            recs_q   <= '0;
            rec_at   <= '0;
            loc_q    <= '0;
            comps_q  <= '0;
            bitpos_q <= '0;
            sum_q    <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state <= S_BASE;
                res_q <= '0;
                err_q <= 1'b0;
                loc_q <= '0;
            end else begin
                case (state)
                    S_IDLE: ;
                    S_FILL: begin
                        if (count >= need_q) state <= resume;
                    end
                    default: begin
                        if (need_on && over) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            state  <= S_IDLE;
                        end else if (need_on && short) begin
                            need_q <= need[CW-1:0];
                            resume <= state;
                            state  <= S_FILL;
                        end else begin
                            case (state)
                                S_BASE: begin
                                    base_q <= win_tag;
                                    if (win_tag == 8'd0) begin
                                        done_q <= 1'b1;
                                        err_q  <= 1'b1;
                                        state  <= S_IDLE;
                                    end else begin
                                        state <= S_NREC;
                                    end
                                end
                                S_NREC: begin
                                    recs_q <= win_tag;
                                    rec_at <= {24'b0, base_q};
                                    state  <= S_TABLE;
                                end
                                S_TABLE: state <= S_REC;
                                S_REC: begin
                                    if (recs_q == 8'd0) begin
                                        state <= S_CHECK;
                                    end else begin
                                        loc_q  <= loc_nx;
                                        recs_q <= recs_q - 8'd1;
                                        rec_at <= rec_at + 32'(REC_LEN);
                                        if (both_found) state <= S_CHECK;
                                    end
                                end
                                S_CHECK: begin
                                    if (loc_q.data_at == 32'd0 || loc_q.sizes_at == 32'd0) begin
                                        done_q <= 1'b1;
                                        err_q  <= 1'b1;
                                        state  <= S_IDLE;
                                    end else begin
                                        state <= S_REACH;
                                    end
                                end
                                S_REACH: state <= S_COUNT;
                                S_COUNT: begin
                                    comps_q  <= window[15:0];
                                    bitpos_q <= '0;
                                    sum_q    <= '0;
                                    state    <= S_FIELD;
                                end
                                S_FIELD: begin
                                    if (comps_q == 16'd0) begin
                                        res_q.start <= loc_q.data_at;
                                        res_q.size  <= sum_q << FRAME_SHIFT;
                                        done_q      <= 1'b1;
                                        state       <= S_IDLE;
                                    end else begin
                                        sum_q    <= acc_next;
                                        bitpos_q <= bitpos_q + 32'(FIELD_W);
                                        comps_q  <= comps_q - 16'd1;
                                    end
                                end
                                default: state <= S_IDLE;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    assign fill_en     = (state == S_FILL);
    assign fill_need   = need_q;
    assign field_shift = bitpos_q[2:0];
    assign acc_sum     = sum_q;
    assign data_start  = res_q.start;
    assign data_size   = res_q.size;
    assign done        = done_q;
    assign err         = err_q;

    // R9
    one_shot_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(err_q) || done_q));

    // R2
    reach_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !err_q) |-> (32'(count) >= res_q.start));

    // R6
    found_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_REACH) |-> (loc_q.data_at != 32'd0 && loc_q.sizes_at != 32'd0));

endmodule

// File: rtl/hdr_image_parser.sv
module hdr_image_parser
    import hdr_parse_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    output logic        byte_ready_o,
    output logic [31:0] data_start_o,
    output logic [31:0] data_size_o,
    output logic        done_o,
    output logic        err_o
);

    localparam int unsigned CW = $clog2(BUF_DEPTH + 1);

    logic [CW-1:0]          count;
    logic                   fill_en;
    logic [CW-1:0]          fill_need;
    logic [31:0]            rd_addr;
    logic [8*WIN_BYTES-1:0] window;
    logic [2:0]             field_shift;
    logic [31:0]            acc_sum, acc_next;

    hdr_byte_buf #(.DEPTH(BUF_DEPTH), .CW(CW)) buf_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_i),
        .fill_en    (fill_en),
        .fill_need  (fill_need),
        .byte_valid (byte_valid_i),
        .byte_in    (byte_i),
        .byte_ready (byte_ready_o),
        .count      (count),
        .rd_addr    (rd_addr),
        .window     (window)
    );

    hdr_field_acc acc_i (
        .window  (window[31:0]),
        .shift   (field_shift),
        .sum_in  (acc_sum),
        .sum_out (acc_next)
    );

    hdr_parse_ctrl #(.DEPTH(BUF_DEPTH), .CW(CW)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .count       (count),
        .fill_en     (fill_en),
        .fill_need   (fill_need),
        .rd_addr     (rd_addr),
        .window      (window),
        .field_shift (field_shift),
        .acc_sum     (acc_sum),
        .acc_next    (acc_next),
        .data_start  (data_start_o),
        .data_size   (data_size_o),
        .done        (done_o),
        .err         (err_o)
    );

endmodule

// File: tb/hdr_image_parser_tb_top.sv
`timescale 1ns/1ps
module hdr_image_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        byte_ready_o;
    logic [31:0] data_start_o, data_size_o;
    logic        done_o, err_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0]  img [0:511];
    logic [21:0] fsz [0:7];

    always #4 clk = ~clk;

    hdr_image_parser #(.BUF_DEPTH(256)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .byte_ready_o (byte_ready_o),
        .data_start_o (data_start_o),
        .data_size_o  (data_size_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 512; i++) img[i] = 8'h00;
    endtask

    task automatic put32(input int pos, input logic [31:0] v);
        for (int b = 0; b < 4; b++) img[pos+b] = v[8*b +: 8];
    endtask

    task automatic put_rec(input int pos, input logic [7:0] tag, input logic [31:0] off);
        img[pos] = tag;
        put32(pos + 1, off);
    endtask

    // pack n 22-bit lengths LSB first starting at byte 'at'
    task automatic pack(input int at, input int n);
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 22; b++) begin
                int bi;
                bi = 22 * i + b;
                img[at + bi / 8][bi % 8] = fsz[i][b];
            end
    endtask

    // start a walk and feed bytes until done; returns bytes taken
    task automatic run_parse(input int gap, output int taken);
        bit got;
        int cyc;
        bit hs;
        got = 0;
        cyc = 0;
        taken = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R9 start clears err", {31'b0, err_o}, 32'd0);
        chk("R9 start clears size", data_size_o, 32'd0);
        while (!got && cyc < 5000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (done_o) begin
                got = 1;
                byte_valid_i = 1'b0;
            end else begin
                byte_valid_i = !(gap > 0 && (cyc % gap) == 0);
                byte_i = img[taken];
                hs = byte_valid_i && byte_ready_o;
                @(posedge clk);
                if (hs) taken++;
            end
        end
        byte_valid_i = 1'b0;
        if (!got) begin
            n_vec++;
            n_bad++;
            $display("FAIL R9 no done: actual 0 expected 1");
        end
    endtask

    // checks at the done cycle and the following one
    task automatic finish_checks(input string tag, input int taken, input logic e_err,
                                 input logic [31:0] e_start, input logic [31:0] e_size,
                                 input int e_taken);
        chk({tag, " err"}, {31'b0, err_o}, {31'b0, e_err});
        chk({tag, " start"}, data_start_o, e_start);
        chk({tag, " size"}, data_size_o, e_size);
        chk("R2 bytes taken", taken, e_taken);
        chk("R2 ready low after end", {31'b0, byte_ready_o}, 32'd0);
        @(negedge clk);
        chk("R9 done single cycle", {31'b0, done_o}, 32'd0);
        chk("R9 size held", data_size_o, e_size);
        chk("R9 err held", {31'b0, err_o}, {31'b0, e_err});
    endtask

    // R3 R4 R7: ignored tag first, packed lengths with all-ones field
    task automatic t_basic();
        int n;
        clear_img();
        img[24] = 8'd64;
        img[63] = 8'd3;
        put_rec(64, 8'd3, 32'd999);
        put_rec(73, 8'd5, 32'd100);
        put_rec(82, 8'd8, 32'd140);
        img[55] = 8'd3;
        fsz[0] = 22'h3FFFFF; fsz[1] = 22'h000001; fsz[2] = 22'h012345;
        pack(100, 3);
        run_parse(0, n);
        finish_checks("R7 basic", n, 1'b0, 32'd140, 32'h04123450, 140);
    endtask

    // R5 R2: payload tag first, decoys after both found, table past payload, stalls
    task automatic t_early_stop();
        int n;
        clear_img();
        img[24] = 8'd72;
        img[71] = 8'd5;
        put_rec(72,  8'd8, 32'd126);
        put_rec(81,  8'd7, 32'd33);
        put_rec(90,  8'd5, 32'd118);
        put_rec(99,  8'd8, 32'd200);
        put_rec(108, 8'd5, 32'd50);
        img[55] = 8'd4;
        fsz[0] = 22'd10; fsz[1] = 22'd20; fsz[2] = 22'd30; fsz[3] = 22'd40;
        pack(118, 4);
        run_parse(3, n);
        finish_checks("R5 early stop", n, 1'b0, 32'd126, 32'd1600, 130);
    endtask

    // R6: length tag present with zero offset
    task automatic t_missing();
        int n;
        clear_img();
        img[24] = 8'd64;
        img[63] = 8'd2;
        put_rec(64, 8'd8, 32'd100);
        put_rec(73, 8'd5, 32'd0);
        run_parse(0, n);
        finish_checks("R6 missing tag", n, 1'b1, 32'd0, 32'd0, 82);
    endtask

    // R8: payload offset beyond buffer depth
    task automatic t_beyond();
        int n;
        clear_img();
        img[24] = 8'd64;
        img[63] = 8'd2;
        put_rec(64, 8'd5, 32'd80);
        put_rec(73, 8'd8, 32'd300);
        run_parse(0, n);
        finish_checks("R8 beyond depth", n, 1'b1, 32'd0, 32'd0, 82);
    endtask

    // R10: zero segments
    task automatic t_empty();
        int n;
        clear_img();
        img[24] = 8'd64;
        img[63] = 8'd2;
        put_rec(64, 8'd5, 32'd90);
        put_rec(73, 8'd8, 32'd96);
        run_parse(2, n);
        finish_checks("R10 zero count", n, 1'b0, 32'd96, 32'd0, 96);
    endtask

    // R8: zero base length
    task automatic t_zero_base();
        int n;
        clear_img();
        run_parse(0, n);
        finish_checks("R8 zero base", n, 1'b1, 32'd0, 32'd0, 71);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 ready", {31'b0, byte_ready_o}, 32'd0);
        chk("R1 done", {31'b0, done_o}, 32'd0);
        chk("R1 err", {31'b0, err_o}, 32'd0);
        chk("R1 start", data_start_o, 32'd0);
        chk("R1 size", data_size_o, 32'd0);
        t_basic();
        t_early_stop();
        t_missing();
        t_basic();
        t_beyond();
        t_empty();
        t_zero_base();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule